// File: doc/BRIEF.md
# Tape Block Read/Write Sequencer

This block steps a tape controller through one block of a tape, one tape line at a time. Each line strobe delivers a decoded timing-track mark and one 3-bit data line. From the marks the block keeps two timing shift registers: one that follows the block-mark area and one that follows the data area. A three-state machine (idle, request, active) decides when characters move. In the active state, a line-pair toggle joins two 3-bit lines into one 6-bit character for a read, or splits one character into two 3-bit lines for a write. When the tape moves backward, both halves are complemented and swapped, except in block-mark mode.

A 6-bit longitudinal checksum is built from the complements of the characters. It is checked when the data area closes. The block raises sticky job-done, information-error, incomplete-block and tape-end flags. A data-channel handshake (`ch_ok`) tells the block whether the channel is still attached and has kept up. When it has, a data-mode block ends back in the request state, ready for the next block.

A start pulse loads a new command. It clears the flags, the timing registers and the character register, and it sets the tape running.

Top module: `tape_line_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `state` is 0 (idle), `run` is 0, and every flag, `rd_valid`, `wr_take` and `wr_en` is 0.
- R2: A `start` pulse clears all flags, sets `run`, and loads `state` from `fcn` in the next cycle. `fcn` bit 2 selects write; bits 1:0 select 01 all, 10 block marks, 11 data. Code 000 gives idle (0), code 100 gives active (2), and every other code gives request (1).
- R3: Mark codes are 0 none, 1 block sync, 2 block space, 3 forward block end, 4 data sync, 5 forward data end, 6 reverse data end, 7 end zone. Data sync loads the top bit of the 9-bit data timing register, and codes 4, 5 and 6 shift it right. In data mode, a request turns active on the line where bit 6 of that register rises.
- R4: Block sync sets the top bit of the 5-bit block timing register, and codes 1 and 2 shift it right. In block-mark mode, a request turns active when bit 0 rises. In all mode, it turns active when bit 3 rises.
- R5: In the active state, the lines alternate odd and even. The odd line gives the high 3 bits and the even line the low 3 bits. On a read, a completed character appears on `rd_char` with a one-cycle `rd_valid` in the cycle after the even line. No character is passed while data-timing bit 6 or bit 1 was set before that line.
- R6: With `rev` high outside block-mark mode, each sensed line is complemented and the two halves of the character are swapped before output.
- R7: The checksum clears on the rise of data-timing bit 6, and on every even line it takes in the complement of the character by XOR. On the rise of bit 0 while active in data mode with `ch_ok` high, a checksum of all ones leaves `info_err` clear and the state returns to request (1).
- R8: At that same rise, a checksum other than all ones sets `info_err`.
- R9: A character passed while `ch_ok` is low sets `incomplete`. At the rise of data-timing bit 0 in data mode while active with `ch_ok` low, `job_done` is set and the state becomes idle.
- R10: In block-mark mode, a forward block end while active sets `job_done` and forces idle.
- R11: Outside all mode, a block sync or data sync mark while active sets `info_err` and forces idle. In all mode, these marks leave the state active.
- R12: An end-zone mark clears `run`, sets `tape_end` and forces idle.
- R13: On a write, the character on `wr_char` is taken on the line that begins a character (a one-cycle `wr_take` follows). `wr_line` then gives its high half on the next line and its low half on the line after, with `wr_en` high.
- R14: Marks presented without `line_stb`, or while `run` is low, do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new command from `fcn` and `rev` |
| fcn | input | 3 | Function code |
| rev | input | 1 | Tape moving backward |
| line_stb | input | 1 | One tape line is present this cycle |
| mark | input | 3 | Decoded timing-track mark for this line |
| sense | input | 3 | Sensed data line |
| ch_ok | input | 1 | Data channel attached and caught up |
| wr_char | input | 6 | Character to write |
| state | output | 2 | 0 idle, 1 request, 2 active |
| run | output | 1 | Tape motion enabled |
| rd_valid | output | 1 | Read character valid (one cycle) |
| rd_char | output | 6 | Read character |
| wr_take | output | 1 | `wr_char` was consumed (one cycle) |
| wr_en | output | 1 | `wr_line` is being written |
| wr_line | output | 3 | Data line to write |
| job_done | output | 1 | Job done flag |
| info_err | output | 1 | Information (checksum or sequence) error flag |
| incomplete | output | 1 | Channel missed a character |
| tape_end | output | 1 | End zone reached |

## Verification
A wrong toggle phase shows up at the very next even line, as a character with its halves exchanged or a `rd_valid` one line late. A wrong bit in a timing register shows up within one or two marks, because the request-to-active step or the return to request lands on the wrong line. A checksum slip stays hidden until the data area closes, and then appears as `info_err` at the end of the block. The bench therefore checks `state` and `rd_valid` after every line of a full block, and checks the flags at the line that ends each scenario.

// File: rtl/tape_seq_pkg.sv
`timescale 1ns/1ps
package tape_seq_pkg;
  typedef enum logic [1:0] {
    RW_IDLE = 2'd0,
    RW_REQ  = 2'd1,
    RW_ACT  = 2'd2
  } rw_st_t;

  // decoded mark codes on the line interface
  localparam logic [2:0] MK_NONE   = 3'd0;
  localparam logic [2:0] MK_BSYNC  = 3'd1;
  localparam logic [2:0] MK_BSPACE = 3'd2;
  localparam logic [2:0] MK_BEND   = 3'd3;
  localparam logic [2:0] MK_DSYNC  = 3'd4;
  localparam logic [2:0] MK_DENDF  = 3'd5;
  localparam logic [2:0] MK_DENDR  = 3'd6;
  localparam logic [2:0] MK_EZONE  = 3'd7;
endpackage

// File: rtl/tape_seq_timing.sv
`timescale 1ns/1ps
module tape_seq_timing
  import tape_seq_pkg::*;
#(
  parameter int BT_W = 5,
  parameter int DT_W = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       adv,
  input  logic [2:0] mark,
  output logic       bt_rise_lo,
  output logic       bt_rise_all,
  output logic       dt_rise_open,
  output logic       dt_rise_close,
  output logic       slot_cur,
  output logic       slot_nxt
);
  localparam int BT_ALL  = BT_W - 2;
  localparam int DT_OPEN = DT_W - 3;

  logic [BT_W-1:0] bt_q, bt_n;
  logic [DT_W-1:0] dt_q, dt_n;

  always_comb begin
    bt_n = bt_q;
    if (mark == MK_BSYNC) bt_n[BT_W-1] = 1'b1;
    if (mark == MK_BSYNC || mark == MK_BSPACE) bt_n = bt_n >> 1;
    dt_n = dt_q;
    if (mark == MK_DSYNC) dt_n = {1'b1, {(DT_W-1){1'b0}}};
    if (mark == MK_DSYNC || mark == MK_DENDF || mark == MK_DENDR) dt_n = dt_n >> 1;
  end

  assign bt_rise_lo    = bt_n[0] & ~bt_q[0];
  assign bt_rise_all   = bt_n[BT_ALL] & ~bt_q[BT_ALL];
  assign dt_rise_open  = dt_n[DT_OPEN] & ~dt_q[DT_OPEN];
  assign dt_rise_close = dt_n[0] & ~dt_q[0];
  // checksum slots: reverse checksum at the open bit, forward checksum at bit 1
  assign slot_cur      = dt_q[DT_OPEN] | dt_q[1];
  assign slot_nxt      = dt_n[DT_OPEN] | dt_n[1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bt_q <= '0;
      dt_q <= '0;
    end else if (adv) begin
      bt_q <= bt_n;
      dt_q <= dt_n;
    end
  end
endmodule

// File: rtl/tape_seq_chardp.sv
`timescale 1ns/1ps
module tape_seq_chardp #(
  parameter int CH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic              strobe_en,
  input  logic              tct,
  input  logic              flip,
  input  logic [CH_W/2-1:0] sense,
  input  logic              lb_clr,
  input  logic              odd_n,
  input  logic              load_en,
  input  logic              load_lb,
  input  logic [CH_W-1:0]   wr_char,
  output logic [CH_W-1:0]   rwb_s,
  output logic [CH_W-1:0]   lb_n,
  output logic [CH_W/2-1:0] out_half
);
  localparam int HALF = CH_W / 2;

  logic [CH_W-1:0] rwb_q, lb_q, rwb_n;
  logic [HALF-1:0] comp;

  assign comp = {HALF{flip}};

  always_comb begin
    // strobe the sensed line into its half
    rwb_s = rwb_q;
    if (strobe_en) begin
      if (tct) rwb_s[HALF-1:0]    = rwb_s[HALF-1:0] | (sense ^ comp);
      else     rwb_s[CH_W-1:HALF] = rwb_s[CH_W-1:HALF] | (sense ^ comp);
    end
    // longitudinal sum of complemented characters
    lb_n = lb_clr ? '0 : lb_q;
    if (tct) lb_n = lb_n ^ ~rwb_s;
    // odd line clears, then a write loads the next character
    rwb_n = odd_n ? '0 : rwb_s;
    if (load_en) begin
      rwb_n = rwb_n | (load_lb ? lb_n : wr_char);
      if (flip) rwb_n = {rwb_n[HALF-1:0], rwb_n[CH_W-1:HALF]};
    end
  end

  assign out_half = (tct ? rwb_q[HALF-1:0] : rwb_q[CH_W-1:HALF]) ^ comp;

  always_ff @(posedge clk) begin
    if (rst) begin
      rwb_q <= '0;
      lb_q  <= '0;
    end else if (clr) begin
      rwb_q <= '0;
    end else if (adv) begin
      rwb_q <= rwb_n;
      lb_q  <= lb_n;
    end
  end
endmodule

// File: rtl/tape_line_seq.sv
`timescale 1ns/1ps
module tape_line_seq
  import tape_seq_pkg::*;
#(
  parameter int CH_W = 6,
  parameter int BT_W = 5,
  parameter int DT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        fcn,
  input  logic              rev,
  input  logic              line_stb,
  input  logic [2:0]        mark,
  input  logic [CH_W/2-1:0] sense,
  input  logic              ch_ok,
  input  logic [CH_W-1:0]   wr_char,
  output logic [1:0]        state,
  output logic              run,
  output logic              rd_valid,
  output logic [CH_W-1:0]   rd_char,
  output logic              wr_take,
  output logic              wr_en,
  output logic [CH_W/2-1:0] wr_line,
  output logic              job_done,
  output logic              info_err,
  output logic              incomplete,
  output logic              tape_end
);
  localparam int HALF = CH_W / 2;

  rw_st_t st_q, st_n, st_start;
  logic   tct_q, tct_n;
  logic   step, fcn_wr, is_all, is_bm, is_data, rev_eff, active;
  logic   bt_rise_lo, bt_rise_all, dt_rise_open, dt_rise_close, slot_cur, slot_nxt;
  logic   emit, odd_n, load_en, take, job_set, cks_bad, act_err, ez;
  logic [CH_W-1:0] rwb_s, lb_n, rd_word;
  logic [HALF-1:0] out_half;

  assign step    = line_stb && run && !start;
  assign fcn_wr  = fcn[2];
  assign is_all  = (fcn[1:0] == 2'b01);
  assign is_bm   = (fcn[1:0] == 2'b10);
  assign is_data = (fcn[1:0] == 2'b11);
  assign rev_eff = rev && !is_bm;
  assign active  = (st_q == RW_ACT);
  assign ez      = (mark == MK_EZONE);

  tape_seq_timing #(.BT_W(BT_W), .DT_W(DT_W)) u_tim (
    .clk(clk), .rst(rst), .clr(start), .adv(step), .mark(mark),
    .bt_rise_lo(bt_rise_lo), .bt_rise_all(bt_rise_all),
    .dt_rise_open(dt_rise_open), .dt_rise_close(dt_rise_close),
    .slot_cur(slot_cur), .slot_nxt(slot_nxt)
  );

  tape_seq_chardp #(.CH_W(CH_W)) u_dp (
    .clk(clk), .rst(rst), .clr(start), .adv(step),
    .strobe_en(active && !fcn_wr), .tct(tct_q), .flip(rev_eff), .sense(sense),
    .lb_clr(dt_rise_open), .odd_n(odd_n), .load_en(load_en), .load_lb(slot_nxt),
    .wr_char(wr_char), .rwb_s(rwb_s), .lb_n(lb_n), .out_half(out_half)
  );

  always_comb begin
    case (fcn)
      3'b000:  st_start = RW_IDLE;
      3'b100:  st_start = RW_ACT;
      default: st_start = RW_REQ;
    endcase
  end

  always_comb begin
    emit    = !fcn_wr && active && tct_q && !slot_cur;
    cks_bad = dt_rise_close && active && (lb_n != {CH_W{1'b1}});
    act_err = !is_all && active && (mark == MK_BSYNC || mark == MK_DSYNC);
    job_set = (is_bm && active && mark == MK_BEND) ||
              (is_data && active && dt_rise_close && !ch_ok);
    st_n = st_q;
    if (st_q == RW_REQ &&
        ((is_bm && bt_rise_lo) || (is_data && dt_rise_open) || (is_all && bt_rise_all)))
      st_n = RW_ACT;
    if (is_data && active && dt_rise_close && ch_ok) st_n = RW_REQ;
    if (act_err) st_n = RW_IDLE;
    if (job_set && !job_done) st_n = RW_IDLE;
    if (ez) st_n = RW_IDLE;
    tct_n   = active ? !tct_q : 1'b0;
    odd_n   = (st_n == RW_ACT) && !tct_n;
    load_en = fcn_wr && odd_n;
    take    = load_en && !slot_nxt;
    rd_word = rev_eff ? {rwb_s[HALF-1:0], rwb_s[CH_W-1:HALF]} : rwb_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RW_IDLE;
      tct_q      <= 1'b0;
      run        <= 1'b0;
      rd_valid   <= 1'b0;
      rd_char    <= '0;
      wr_take    <= 1'b0;
      wr_en      <= 1'b0;
      wr_line    <= '0;
      job_done   <= 1'b0;
      info_err   <= 1'b0;
      incomplete <= 1'b0;
      tape_end   <= 1'b0;
    end else if (start) begin
      st_q       <= st_start;
      tct_q      <= 1'b0;
      run        <= 1'b1;
      rd_valid   <= 1'b0;
      wr_take    <= 1'b0;
      wr_en      <= 1'b0;
      job_done   <= 1'b0;
      info_err   <= 1'b0;
      incomplete <= 1'b0;
      tape_end   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      if (step) begin
        st_q       <= st_n;
        tct_q      <= tct_n;
        rd_valid   <= emit;
        if (emit) rd_char <= rd_word;
        wr_take    <= take;
        wr_en      <= fcn_wr && active;
        wr_line    <= out_half;
        job_done   <= job_done | job_set;
        info_err   <= info_err | cks_bad | act_err;
        incomplete <= incomplete | ((emit || take) && !ch_ok);
        tape_end   <= tape_end | ez;
        if (ez) run <= 1'b0;
      end
    end
  end

  assign state = st_q;
endmodule

// File: rtl/tape_line_seq_chk.sv
`timescale 1ns/1ps
module tape_line_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       line_stb,
  input logic       fcn_wr,
  input logic [1:0] state,
  input logic       run,
  input logic       rd_valid,
  input logic       wr_take,
  input logic       job_done,
  input logic       info_err,
  input logic       incomplete,
  input logic       tape_end
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> run && !job_done && !info_err && !incomplete && !tape_end);
  // R5
  rd_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(line_stb) && ($past(state) == 2'd2) && !$past(fcn_wr));
  // R9
  job_forces_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(job_done) |-> state == 2'd0);
  // R12
  end_zone_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tape_end) |-> !run && state == 2'd0);
  // R13
  take_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> $past(fcn_wr) && $past(line_stb));
  // R14
  no_line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!line_stb && !start) |=> $stable(state));
endmodule

bind tape_line_seq tape_line_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .line_stb(line_stb), .fcn_wr(fcn[2]),
  .state(state), .run(run), .rd_valid(rd_valid), .wr_take(wr_take),
  .job_done(job_done), .info_err(info_err), .incomplete(incomplete),
  .tape_end(tape_end)
);

// File: tb/tape_line_seq_test.sv
`timescale 1ns/1ps
module tape_line_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] fcn = 3'b000;
  logic       rev = 1'b0;
  logic       line_stb = 1'b0;
  logic [2:0] mark = 3'd0;
  logic [2:0] sense = 3'd0;
  logic       ch_ok = 1'b1;
  logic [5:0] wr_char = 6'o00;
  logic [1:0] state;
  logic       run, rd_valid, wr_take, wr_en, job_done, info_err, incomplete, tape_end;
  logic [5:0] rd_char;
  logic [2:0] wr_line;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  tape_line_seq uut (
    .clk(clk), .rst(rst), .start(start), .fcn(fcn), .rev(rev), .line_stb(line_stb),
    .mark(mark), .sense(sense), .ch_ok(ch_ok), .wr_char(wr_char), .state(state),
    .run(run), .rd_valid(rd_valid), .rd_char(rd_char), .wr_take(wr_take),
    .wr_en(wr_en), .wr_line(wr_line), .job_done(job_done), .info_err(info_err),
    .incomplete(incomplete), .tape_end(tape_end)
  );

  // one forward data block: {mark, sense, expected state, expected valid, expected char}
  localparam logic [14:0] BLK [14] = '{
    {3'd4, 3'd0, 2'd1, 1'b0, 6'o00},
    {3'd5, 3'd0, 2'd2, 1'b0, 6'o00},
    {3'd0, 3'd1, 2'd2, 1'b0, 6'o00},
    {3'd5, 3'd2, 2'd2, 1'b0, 6'o00},
    {3'd0, 3'd3, 2'd2, 1'b0, 6'o00},
    {3'd5, 3'd4, 2'd2, 1'b1, 6'o34},
    {3'd0, 3'd5, 2'd2, 1'b0, 6'o00},
    {3'd5, 3'd6, 2'd2, 1'b1, 6'o56},
    {3'd0, 3'd7, 2'd2, 1'b0, 6'o00},
    {3'd5, 3'd0, 2'd2, 1'b1, 6'o70},
    {3'd0, 3'd0, 2'd2, 1'b0, 6'o00},
    {3'd5, 3'd1, 2'd2, 1'b1, 6'o01},
    {3'd0, 3'd7, 2'd2, 1'b0, 6'o00},
    {3'd5, 3'd6, 2'd1, 1'b0, 6'o00}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic line(input logic [2:0] mk, input logic [2:0] sn);
    mark = mk; sense = sn; line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0; mark = 3'd0;
  endtask

  task automatic go(input logic [2:0] f, input logic r);
    fcn = f; rev = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed_block(input logic [2:0] last_sense);
    for (int i = 0; i < 14; i++)
      line(BLK[i][14:12], (i == 13) ? last_sense : BLK[i][11:9]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 run", run, 0);
    check("R1 flags", {job_done, info_err, incomplete, tape_end}, 0);
    check("R1 rd_valid/wr_en", {rd_valid, wr_en, wr_take}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", state, 0);

    // R2 start codes
    go(3'b000, 1'b0);
    check("R2 fcn000 state", state, 0);
    check("R2 run", run, 1);
    go(3'b100, 1'b0);
    check("R2 fcn100 state", state, 2);
    go(3'b011, 1'b0);
    check("R2 fcn011 state", state, 1);

    // R14 marks without a line strobe
    mark = 3'd4; @(negedge clk);
    mark = 3'd5; @(negedge clk);
    mark = 3'd0;
    check("R14 no strobe", state, 1);

    // table walk: R3 activation, R5 assembly, R7 block end
    for (int i = 0; i < 14; i++) begin
      line(BLK[i][14:12], BLK[i][11:9]);
      check((i == 1) ? "R3 state" : ((i == 13) ? "R7 state" : "R5 state"), state, BLK[i][8:7]);
      check("R5 rd_valid", rd_valid, BLK[i][6]);
      if (BLK[i][6]) check("R5 rd_char", rd_char, BLK[i][5:0]);
    end
    check("R7 no info_err", info_err, 0);

    // R8 bad checksum
    go(3'b011, 1'b0);
    feed_block(3'd5);
    check("R8 info_err", info_err, 1);
    check("R8 state", state, 1);

    // R9 channel disconnected
    ch_ok = 1'b0;
    go(3'b011, 1'b0);
    feed_block(3'd6);
    check("R9 incomplete", incomplete, 1);
    check("R9 job_done", job_done, 1);
    check("R9 state", state, 0);
    ch_ok = 1'b1;

    // R6 reverse read
    go(3'b011, 1'b1);
    line(3'd4, 3'd0); line(3'd6, 3'd0); line(3'd0, 3'd0); line(3'd6, 3'd0);
    line(3'd0, 3'd3); line(3'd6, 3'd5);
    check("R6 rd_valid", rd_valid, 1);
    check("R6 rd_char", rd_char, 6'o24);

    // R4 block-mark mode, then R10
    go(3'b010, 1'b1);
    line(3'd1, 3'd0);
    check("R4 bm after sync", state, 1);
    line(3'd2, 3'd0); line(3'd2, 3'd0);
    check("R4 bm before lo", state, 1);
    line(3'd2, 3'd0);
    check("R4 bm active", state, 2);
    line(3'd3, 3'd0);
    check("R10 job_done", job_done, 1);
    check("R10 state", state, 0);

    // R4 all mode, R11 exemption
    go(3'b001, 1'b0);
    line(3'd1, 3'd0);
    check("R4 all active", state, 2);
    line(3'd4, 3'd0);
    check("R11 all-mode state", state, 2);
    check("R11 all-mode info_err", info_err, 0);

    // R11 sync while active in data mode
    go(3'b011, 1'b0);
    line(3'd4, 3'd0); line(3'd5, 3'd0);
    check("R11 pre active", state, 2);
    line(3'd4, 3'd0);
    check("R11 info_err", info_err, 1);
    check("R11 state", state, 0);

    // R13 write split
    wr_char = 6'o53;
    go(3'b111, 1'b0);
    line(3'd4, 3'd0); line(3'd5, 3'd0); line(3'd0, 3'd0);
    check("R13 no take yet", wr_take, 0);
    line(3'd5, 3'd0);
    check("R13 take", wr_take, 1);
    line(3'd0, 3'd0);
    check("R13 wr_en", wr_en, 1);
    check("R13 high half", wr_line, 5);
    line(3'd0, 3'd0);
    check("R13 low half", wr_line, 3);

    // R12 end zone, R14 lines while stopped
    go(3'b011, 1'b0);
    line(3'd7, 3'd0);
    check("R12 tape_end", tape_end, 1);
    check("R12 run", run, 0);
    check("R12 state", state, 0);
    line(3'd4, 3'd0); line(3'd5, 3'd0);
    check("R14 stopped state", state, 0);
    check("R14 stopped rd_valid", rd_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule